// File: doc/BRIEF.md
# Virtual Address Translation Unit

This block turns a 32-bit virtual address into a physical address for a single access at a time. It splits the address into a 20-bit page number and a 12-bit offset. It finds which fixed partition the address lies in, and it either maps the address straight to low memory or looks it up in a small fully associative TLB. TLB entries are keyed by page number together with a process identifier.

Each access gives the address, the process identifier, the access kind (read, write or execute) and a user-mode flag. The result is a physical address, a cacheable flag and a two-bit exception code, all produced combinationally from the inputs and the current TLB contents. Software fills the TLB one entry per clock through a write port that selects an entry by index. A page-table walker, the caches and the pipeline lie outside this block.

Top module: `va_xlate`

## Requirements
- R1: The low 12 bits of the address (the page offset) reach the physical address unchanged on every access that raises no exception.
- R2: A TLB entry matches only when it is valid and both its page number (address bits 31:12) and its process identifier equal those of the access.
- R3: On a permitted TLB hit, the physical address is the entry's frame number followed by the page offset, and the cacheable flag is the entry's cacheable bit.
- R4: The access kind selects the permission bit that is checked: 0 = read checks perm bit 0, 1 = write checks perm bit 1, 2 = execute checks perm bit 2. Kind 3 is never permitted.
- R5: Exception codes are 0 none, 1 TLB miss, 2 permission violation and 3 supervisor-only partition in user mode. On any exception the physical address and the cacheable flag are 0.
- R6: Addresses with bits 31:29 = 111 bypass the TLB, are never cacheable, and map to the address with bits 31:29 cleared.
- R7: Addresses with bits 31:29 = 110 bypass the TLB, are always cacheable, and map to the address with bits 31:29 cleared.
- R8: Addresses with bit 31 = 1 raise code 3 in user mode. This takes priority over a miss or a permission fault. Addresses with bits 31:29 = 10x or bit 31 = 0 are translated through the TLB.
- R9: The TLB has 16 entries, all invalid after reset. A write stores valid, page number, process identifier, frame number, permissions and cacheable bit at the given index, and takes effect at the next rising clock edge. Writing valid = 0 removes the entry.
- R10: When several entries match, the lowest-indexed one is used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| va_i | input | 32 | Virtual address |
| pid_i | input | 8 | Current process identifier |
| acc_i | input | 2 | Access kind: 0 read, 1 write, 2 execute |
| user_i | input | 1 | 1 = user mode, 0 = supervisor |
| tlb_we_i | input | 1 | TLB entry write enable |
| tlb_idx_i | input | 4 | Entry index to write |
| tlb_valid_i | input | 1 | Valid bit to store |
| tlb_vpn_i | input | 20 | Page number to store |
| tlb_pid_i | input | 8 | Process identifier to store |
| tlb_pfn_i | input | 20 | Frame number to store |
| tlb_perm_i | input | 3 | Permissions: bit 0 read, bit 1 write, bit 2 execute |
| tlb_cache_i | input | 1 | Cacheable bit to store |
| pa_o | output | 32 | Physical address |
| cacheable_o | output | 1 | Access may be cached |
| exc_o | output | 2 | Exception code |

## Verification
The assertions sample the combinational outputs at the rising edge and assume the access inputs are stable across that edge. They also assume that the index of a TLB write always falls within the 16 entries. The bench changes every input only on the falling edge and compares results in the middle of the low phase. Its write indices are all below 16. Entries are written with deliberate overlaps: the same page under two process identifiers, and two entries holding the same page. These overlaps exercise key matching and the lowest-index priority.

// File: rtl/va_xlate_pkg.sv
package va_xlate_pkg;
  localparam int VA_W  = 32;
  localparam int OFF_W = 12;
  localparam int VPN_W = VA_W - OFF_W;

  typedef enum logic [1:0] {
    EXC_NONE = 2'd0,
    EXC_MISS = 2'd1,
    EXC_PERM = 2'd2,
    EXC_PRIV = 2'd3
  } exc_e;

  typedef enum logic [1:0] {
    ACC_RD  = 2'd0,
    ACC_WR  = 2'd1,
    ACC_EX  = 2'd2,
    ACC_RSV = 2'd3
  } acc_e;

  typedef enum logic [1:0] {
    PART_USER,
    PART_KMAP,
    PART_KDIR,
    PART_IO
  } part_e;
endpackage

// File: rtl/va_xlate_part.sv
module va_xlate_part
  import va_xlate_pkg::*;
(
  input  logic [2:0] top_i,
  output part_e      part_o,
  output logic       bypass_o,
  output logic       priv_only_o,
  output logic       fixed_cache_o
);
  always_comb begin
    case (top_i)
      3'b111:         part_o = PART_IO;
      3'b110:         part_o = PART_KDIR;
      3'b100, 3'b101: part_o = PART_KMAP;
      default:        part_o = PART_USER;
    endcase
  end

  assign bypass_o      = (part_o == PART_IO) || (part_o == PART_KDIR);
  assign priv_only_o   = (part_o != PART_USER);
  assign fixed_cache_o = (part_o == PART_KDIR);
endmodule

// File: rtl/va_xlate_tlb.sv
module va_xlate_tlb
  import va_xlate_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int PID_W   = 8,
  parameter int PFN_W   = 20,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic             wr_valid_i,
  input  logic [VPN_W-1:0] wr_vpn_i,
  input  logic [PID_W-1:0] wr_pid_i,
  input  logic [PFN_W-1:0] wr_pfn_i,
  input  logic [2:0]       wr_perm_i,
  input  logic             wr_cache_i,
  input  logic [VPN_W-1:0] lk_vpn_i,
  input  logic [PID_W-1:0] lk_pid_i,
  output logic             hit_o,
  output logic [PFN_W-1:0] pfn_o,
  output logic [2:0]       perm_o,
  output logic             cache_o
);
  typedef struct packed {
    logic             valid;
    logic [VPN_W-1:0] vpn;
    logic [PID_W-1:0] pid;
    logic [PFN_W-1:0] pfn;
    logic [2:0]       perm;
    logic             cache;
  } entry_t;

  entry_t             ent_q [ENTRIES];
  logic [ENTRIES-1:0] match_vec;
  logic [IDX_W-1:0]   sel;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ent_q[i] <= '0;
      end else if (wr_en_i && (wr_idx_i == IDX_W'(i))) begin
        ent_q[i] <= '{valid: wr_valid_i, vpn: wr_vpn_i, pid: wr_pid_i,
                      pfn: wr_pfn_i, perm: wr_perm_i, cache: wr_cache_i};
      end
    end
    assign match_vec[i] = ent_q[i].valid && (ent_q[i].vpn == lk_vpn_i) &&
                          (ent_q[i].pid == lk_pid_i);
  end

  // lowest index wins
  always_comb begin
    sel = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (match_vec[i]) sel = IDX_W'(i);
    end
  end

  assign hit_o   = |match_vec;
  assign pfn_o   = ent_q[sel].pfn;
  assign perm_o  = ent_q[sel].perm;
  assign cache_o = ent_q[sel].cache;

  // R9
  tlb_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> (ent_q[$past(wr_idx_i)].valid == $past(wr_valid_i)));

  // R10
  lowest_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> ((match_vec & ((ENTRIES'(1) << sel) - ENTRIES'(1))) == '0));
endmodule

// File: rtl/va_xlate.sv
module va_xlate
  import va_xlate_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int PID_W   = 8,
  parameter int PFN_W   = 20,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int PA_W   = PFN_W + OFF_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [VA_W-1:0]  va_i,
  input  logic [PID_W-1:0] pid_i,
  input  logic [1:0]       acc_i,
  input  logic             user_i,
  input  logic             tlb_we_i,
  input  logic [IDX_W-1:0] tlb_idx_i,
  input  logic             tlb_valid_i,
  input  logic [VPN_W-1:0] tlb_vpn_i,
  input  logic [PID_W-1:0] tlb_pid_i,
  input  logic [PFN_W-1:0] tlb_pfn_i,
  input  logic [2:0]       tlb_perm_i,
  input  logic             tlb_cache_i,
  output logic [PA_W-1:0]  pa_o,
  output logic             cacheable_o,
  output logic [1:0]       exc_o
);
  part_e            part;
  logic             bypass, priv_only, fixed_cache;
  logic             hit, ent_cache, allowed;
  logic [PFN_W-1:0] ent_pfn;
  logic [2:0]       ent_perm;
  exc_e             exc;

  va_xlate_part u_part (
    .top_i         (va_i[VA_W-1 -: 3]),
    .part_o        (part),
    .bypass_o      (bypass),
    .priv_only_o   (priv_only),
    .fixed_cache_o (fixed_cache)
  );

  va_xlate_tlb #(
    .ENTRIES (ENTRIES),
    .PID_W   (PID_W),
    .PFN_W   (PFN_W)
  ) u_tlb (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (tlb_we_i),
    .wr_idx_i   (tlb_idx_i),
    .wr_valid_i (tlb_valid_i),
    .wr_vpn_i   (tlb_vpn_i),
    .wr_pid_i   (tlb_pid_i),
    .wr_pfn_i   (tlb_pfn_i),
    .wr_perm_i  (tlb_perm_i),
    .wr_cache_i (tlb_cache_i),
    .lk_vpn_i   (va_i[VA_W-1:OFF_W]),
    .lk_pid_i   (pid_i),
    .hit_o      (hit),
    .pfn_o      (ent_pfn),
    .perm_o     (ent_perm),
    .cache_o    (ent_cache)
  );

  always_comb begin
    case (acc_e'(acc_i))
      ACC_RD:  allowed = ent_perm[0];
      ACC_WR:  allowed = ent_perm[1];
      ACC_EX:  allowed = ent_perm[2];
      default: allowed = 1'b0;
    endcase
  end

  always_comb begin
    exc         = EXC_NONE;
    pa_o        = '0;
    cacheable_o = 1'b0;
    if (user_i && priv_only) begin
      exc = EXC_PRIV;
    end else if (bypass) begin
      pa_o        = PA_W'(va_i[VA_W-4:0]);
      cacheable_o = fixed_cache;
    end else if (!hit) begin
      exc = EXC_MISS;
    end else if (!allowed) begin
      exc = EXC_PERM;
    end else begin
      pa_o        = {ent_pfn, va_i[OFF_W-1:0]};
      cacheable_o = ent_cache;
    end
  end

  assign exc_o = exc;

  // R1
  offset_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exc_o == EXC_NONE) |-> (pa_o[OFF_W-1:0] == va_i[OFF_W-1:0]));

  // R5
  exc_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exc_o != EXC_NONE) |-> ((pa_o == '0) && !cacheable_o));

  // R6
  io_window_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((va_i[31:29] == 3'b111) && !user_i) |->
      ((exc_o == EXC_NONE) && !cacheable_o && (pa_o == PA_W'(va_i[28:0]))));

  // R7
  kdir_window_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((va_i[31:29] == 3'b110) && !user_i) |->
      ((exc_o == EXC_NONE) && cacheable_o && (pa_o == PA_W'(va_i[28:0]))));

  // R8
  user_priv_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (user_i && va_i[31]) |-> (exc_o == EXC_PRIV));
endmodule

// File: tb/tb_va_xlate.sv
module tb_va_xlate;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] va = '0;
  logic [7:0]  pid = '0;
  logic [1:0]  acc = '0;
  logic        user = 1'b0;
  logic        we = 1'b0;
  logic [3:0]  idx = '0;
  logic        wvalid = 1'b0;
  logic [19:0] wvpn = '0;
  logic [7:0]  wpid = '0;
  logic [19:0] wpfn = '0;
  logic [2:0]  wperm = '0;
  logic        wcache = 1'b0;
  logic [31:0] pa;
  logic        cach;
  logic [1:0]  exc;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  va_xlate dut (
    .clk_i(clk), .rst_ni(rst_n), .va_i(va), .pid_i(pid), .acc_i(acc),
    .user_i(user), .tlb_we_i(we), .tlb_idx_i(idx), .tlb_valid_i(wvalid),
    .tlb_vpn_i(wvpn), .tlb_pid_i(wpid), .tlb_pfn_i(wpfn), .tlb_perm_i(wperm),
    .tlb_cache_i(wcache), .pa_o(pa), .cacheable_o(cach), .exc_o(exc)
  );

  typedef struct packed {
    logic [31:0] va;
    logic [7:0]  pid;
    logic [1:0]  acc;
    logic        user;
    logic [31:0] pa;
    logic        c;
    logic [1:0]  exc;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VECS [NV] = '{
    '{32'h00010ABC, 8'd5, 2'd0, 1'b1, 32'h12345ABC, 1'b1, 2'd0, 8'd3},  // R3
    '{32'h00010ABC, 8'd5, 2'd1, 1'b1, 32'h0,        1'b0, 2'd2, 8'd4},  // R4
    '{32'h00010ABC, 8'd7, 2'd1, 1'b1, 32'h0ABCDABC, 1'b0, 2'd0, 8'd2},  // R2
    '{32'h00010ABC, 8'd9, 2'd0, 1'b1, 32'h0,        1'b0, 2'd1, 8'd2},  // R2
    '{32'h80001004, 8'd5, 2'd1, 1'b0, 32'h00F00004, 1'b1, 2'd0, 8'd8},  // R8
    '{32'h80001004, 8'd5, 2'd2, 1'b0, 32'h0,        1'b0, 2'd2, 8'd4},  // R4
    '{32'h80001004, 8'd5, 2'd0, 1'b1, 32'h0,        1'b0, 2'd3, 8'd8},  // R8
    '{32'hE0001234, 8'd0, 2'd0, 1'b0, 32'h00001234, 1'b0, 2'd0, 8'd6},  // R6
    '{32'hE0001234, 8'd0, 2'd0, 1'b1, 32'h0,        1'b0, 2'd3, 8'd8},  // R8
    '{32'hC0005678, 8'd0, 2'd2, 1'b0, 32'h00005678, 1'b1, 2'd0, 8'd7},  // R7
    '{32'hDFFFFFFF, 8'd3, 2'd1, 1'b0, 32'h1FFFFFFF, 1'b1, 2'd0, 8'd7},  // R7
    '{32'h00020010, 8'd5, 2'd2, 1'b1, 32'h11111010, 1'b0, 2'd0, 8'd1},  // R1
    '{32'h00020010, 8'd5, 2'd0, 1'b1, 32'h0,        1'b0, 2'd2, 8'd5},  // R5
    '{32'h00030FFF, 8'd5, 2'd0, 1'b1, 32'h33333FFF, 1'b0, 2'd0, 8'd10}, // R10
    '{32'h90000000, 8'd5, 2'd0, 1'b0, 32'h0,        1'b0, 2'd1, 8'd5},  // R5
    '{32'hA0000000, 8'd5, 2'd0, 1'b1, 32'h0,        1'b0, 2'd3, 8'd8},  // R8
    '{32'h00030000, 8'd5, 2'd3, 1'b0, 32'h0,        1'b0, 2'd2, 8'd4},  // R4
    '{32'h7FFFF000, 8'd5, 2'd0, 1'b1, 32'h0,        1'b0, 2'd1, 8'd5}   // R5
  };

  task automatic check(input int req, input logic [34:0] got, input logic [34:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL R%0d: got pa=%h c=%b exc=%0d, expected pa=%h c=%b exc=%0d",
               req, got[34:3], got[2], got[1:0], exp[34:3], exp[2], exp[1:0]);
    end
  endtask

  task automatic lookup(input logic [31:0] a, input logic [7:0] p,
                        input logic [1:0] k, input logic u);
    @(negedge clk);
    va = a; pid = p; acc = k; user = u;
    #5;
  endtask

  task automatic tlb_write(input logic [3:0] i, input logic v, input logic [19:0] vpn,
                           input logic [7:0] p, input logic [19:0] pfn,
                           input logic [2:0] perm, input logic c);
    @(negedge clk);
    we = 1'b1; idx = i; wvalid = v; wvpn = vpn; wpid = p; wpfn = pfn;
    wperm = perm; wcache = c;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(20 * 100000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: got timeout, expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R9: all entries invalid after reset
    lookup(32'h00010ABC, 8'd5, 2'd0, 1'b1);
    check(9, {pa, cach, exc}, {32'h0, 1'b0, 2'd1});
    lookup(32'h00000000, 8'd0, 2'd0, 1'b0);
    check(9, {pa, cach, exc}, {32'h0, 1'b0, 2'd1});

    // R9: write lands on the next edge
    @(negedge clk);
    va = 32'h00010ABC; pid = 8'd5; acc = 2'd0; user = 1'b1;
    we = 1'b1; idx = 4'd0; wvalid = 1'b1; wvpn = 20'h00010; wpid = 8'd5;
    wpfn = 20'h12345; wperm = 3'b001; wcache = 1'b1;
    #5;
    check(9, {pa, cach, exc}, {32'h0, 1'b0, 2'd1});
    @(negedge clk);
    we = 1'b0;
    #5;
    check(9, {pa, cach, exc}, {32'h12345ABC, 1'b1, 2'd0});

    tlb_write(4'd1,  1'b1, 20'h00010, 8'd7, 20'h0ABCD, 3'b111, 1'b0);
    tlb_write(4'd2,  1'b1, 20'h80001, 8'd5, 20'h00F00, 3'b011, 1'b1);
    tlb_write(4'd3,  1'b1, 20'h00020, 8'd5, 20'h11111, 3'b100, 1'b0);
    tlb_write(4'd15, 1'b1, 20'h00030, 8'd5, 20'h22222, 3'b111, 1'b1);
    tlb_write(4'd14, 1'b1, 20'h00030, 8'd5, 20'h33333, 3'b111, 1'b0);

    for (int i = 0; i < NV; i++) begin
      lookup(VECS[i].va, VECS[i].pid, VECS[i].acc, VECS[i].user);
      check(int'(VECS[i].req), {pa, cach, exc}, {VECS[i].pa, VECS[i].c, VECS[i].exc});
    end

    // R10: drop entry 14, entry 15 now serves the page
    tlb_write(4'd14, 1'b0, 20'h00030, 8'd5, 20'h33333, 3'b111, 1'b0);
    lookup(32'h00030123, 8'd5, 2'd1, 1'b1);
    check(10, {pa, cach, exc}, {32'h22222123, 1'b1, 2'd0});

    // R9: invalidate entry 3
    tlb_write(4'd3, 1'b0, 20'h00020, 8'd5, 20'h11111, 3'b100, 1'b0);
    lookup(32'h00020010, 8'd5, 2'd2, 1'b1);
    check(9, {pa, cach, exc}, {32'h0, 1'b0, 2'd1});

    // R4: write permission granted on a kernel mapped page
    lookup(32'h80001FFC, 8'd5, 2'd1, 1'b0);
    check(4, {pa, cach, exc}, {32'h00F00FFC, 1'b1, 2'd0});

    // R6: top of the I/O window in supervisor mode
    lookup(32'hFFFFFFFF, 8'd0, 2'd1, 1'b0);
    check(6, {pa, cach, exc}, {32'h1FFFFFFF, 1'b0, 2'd0});

    // R9: reset clears the TLB again
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    lookup(32'h00010ABC, 8'd7, 2'd0, 1'b1);
    check(9, {pa, cach, exc}, {32'h0, 1'b0, 2'd1});

    finish_run();
  end
endmodule